// File: doc/BRIEF.md
# Byte-Wide SPI Master/Slave Port

This block is a synchronous serial port that moves one byte at a time, MSB first, in either direction at once. The CPU side programs a small configuration register (enable, clock polarity, 4-bit mode) and talks to a single data buffer. A buffer write loads the shifter and, in master mode, starts the transfer. The byte received during that transfer lands in the same buffer, which sets a buffer-full status. Reading the buffer clears that status.

In master mode the port makes SCK itself. It either divides the system clock by one of three fixed ratios or toggles SCK once for each external timer tick. In slave mode it takes SCK from the pin through a two-flop synchroniser with edge detection. Slave select can gate the transfer or be ignored. SDO changes on the leading SCK edge and SDI is sampled on the trailing edge. Two sticky flags report a write collision and a slave receive overflow. Both stay set until `flags_clr_i` is pulsed.

Top module: `spi_port`

## Requirements
- R1: Modes 4'b0000, 4'b0001 and 4'b0010 are master modes that divide the system clock by 4, 16 and 64. `done_o` is high in the cycle after the clock edge that lies 8*div edges past the edge that captures the buffer write. With SDO looped back to SDI, the received byte equals the byte written.
- R2: Mode 4'b0011 is a master mode in which SCK changes level once per cycle in which `tmr_tick_i` is high. A byte completes after exactly 16 ticks.
- R3: Mode 4'b0100 is a slave mode with slave-select gating:
  - while `ss_ni` is high, SCK edges are ignored and `sdo_oe_o` is 0;
  - raising `ss_ni` mid-byte discards the partial bit count.
  Mode 4'b0101 is a slave mode that ignores `ss_ni`.
- R4: `cfg_cpol_i`=1 makes SCK idle high and `cfg_cpol_i`=0 makes it idle low. The leading edge is the transition away from the idle level.
- R5: In slave mode, when a byte completes while `buf_full_o` is 1, `rov_o` sets and `buf_rdata_o` keeps its old value.
- R6: `rov_o` never sets in master mode. A completed master byte always replaces the buffer.
- R7: A buffer write while a byte is being shifted sets `wcol_o`. That write is ignored. `wcol_o` and `rov_o` stay set until `flags_clr_i`.
- R8: After reset, all configuration bits are 0. With the enable bit at 0, `sck_oe_o`, `sdo_oe_o`, `buf_full_o`, `wcol_o` and `rov_o` are 0, and buffer writes start nothing.
- R9: Mode codes 4'b0110 to 4'b1111 are reserved. They leave the port idle with `sck_oe_o`=0, and buffer writes neither start a transfer nor set `wcol_o`.
- R10: Data shifts MSB first. In slave mode, SDO presents bit 7 of the loaded byte after the first leading edge, and the next bit after each later leading edge.
- R11: A completed byte pulses `done_o` for exactly one cycle and sets `buf_full_o`. A pulse on `buf_rd_i` clears `buf_full_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load configuration fields |
| cfg_en_i | input | 1 | Port enable |
| cfg_cpol_i | input | 1 | SCK idle level |
| cfg_mode_i | input | 4 | Role and clock-source code |
| buf_wr_i | input | 1 | Buffer write strobe |
| buf_wdata_i | input | 8 | Byte to transmit |
| buf_rd_i | input | 1 | Buffer read strobe, clears full status |
| buf_rdata_o | output | 8 | Last received byte |
| buf_full_o | output | 1 | Unread received byte present |
| done_o | output | 1 | One-cycle byte-complete pulse |
| flags_clr_i | input | 1 | Clears both sticky flags |
| wcol_o | output | 1 | Sticky write-collision flag |
| rov_o | output | 1 | Sticky receive-overflow flag |
| tmr_tick_i | input | 1 | External timer tick for mode 4'b0011 |
| sck_i | input | 1 | SCK pin input (slave) |
| sck_o | output | 1 | SCK drive value (master) |
| sck_oe_o | output | 1 | SCK output enable |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | SDO output enable |
| ss_ni | input | 1 | Slave select, active low |

## Verification
Master latency is exact. The bench stamps the cycle in which it drives a write. It then expects `done_o` at a negative edge exactly 8*div+1 rising edges later, and expects it low again at the next negative edge. In timer mode, each tick is a one-cycle pulse, and `done_o` is checked one edge after each tick, so the count must be exactly 16. On the slave side the pin goes through two synchroniser flops plus an edge register. The bench therefore holds every SCK half period for six system cycles and samples SDO and the buffer only at the end of a half period, after that three-edge delay has settled.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef enum logic [1:0] {ROLE_OFF, ROLE_MASTER, ROLE_SLAVE} role_e;

  localparam logic [3:0] MODE_SLV_SS = 4'b0100;

  function automatic role_e mode_role(input logic [3:0] m);
    case (m)
      4'b0000, 4'b0001, 4'b0010, 4'b0011: return ROLE_MASTER;
      4'b0100, 4'b0101:                   return ROLE_SLAVE;
      default:                            return ROLE_OFF;
    endcase
  endfunction
endpackage

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen #(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  input  logic       tick_i,
  output logic       edge_o
);
  localparam int HALF_A = DIV_A / 2;
  localparam int HALF_B = DIV_B / 2;
  localparam int HALF_C = DIV_C / 2;
  localparam int CW     = $clog2(HALF_C + 1);

  logic [CW-1:0] cnt_q, lim;
  logic          use_tick, hit;

  always_comb begin
    case (sel_i)
      2'd0:    lim = CW'(HALF_A - 1);
      2'd1:    lim = CW'(HALF_B - 1);
      default: lim = CW'(HALF_C - 1);
    endcase
  end

  assign use_tick = (sel_i == 2'd3);
  assign hit      = (cnt_q == lim);
  assign edge_o   = run_i & (use_tick ? tick_i : hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || use_tick) cnt_q <= '0;
    else if (hit)                cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic ss_ni,
  input  logic cpol_i,
  output logic lead_o,
  output logic trail_o,
  output logic ss_n_o
);
  logic [STAGES:0]   sck_sh;
  logic [STAGES-1:0] ss_sh;
  logic              rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sh <= '0;
      ss_sh  <= '1;
    end else begin
      sck_sh <= {sck_sh[STAGES-1:0], sck_i};
      ss_sh  <= {ss_sh[STAGES-2:0], ss_ni};
    end
  end

  assign rise    =  sck_sh[STAGES-1] & ~sck_sh[STAGES];
  assign fall    = ~sck_sh[STAGES-1] &  sck_sh[STAGES];
  assign lead_o  = cpol_i ? fall : rise;
  assign trail_o = cpol_i ? rise : fall;
  assign ss_n_o  = ss_sh[STAGES-1];
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_A       = 4,
  parameter int DIV_B       = 16,
  parameter int DIV_C       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_en_i,
  input  logic              cfg_cpol_i,
  input  logic [3:0]        cfg_mode_i,
  input  logic              buf_wr_i,
  input  logic [DATA_W-1:0] buf_wdata_i,
  input  logic              buf_rd_i,
  output logic [DATA_W-1:0] buf_rdata_o,
  output logic              buf_full_o,
  output logic              done_o,
  input  logic              flags_clr_i,
  output logic              wcol_o,
  output logic              rov_o,
  input  logic              tmr_tick_i,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              ss_ni
);
  localparam int BW = $clog2(DATA_W);

  logic              en_q, cpol_q;
  logic [3:0]        mode_q;
  logic [DATA_W-1:0] sr_q, rxbuf_q;
  logic [BW-1:0]     bit_q;
  logic              busy_q, mid_q, sdo_q, sck_q, full_q, done_q, wcol_q, rov_q;

  logic is_m, is_s, ss_block, m_edge, s_lead, s_trail, ss_n_s;
  logic lead, trail, active, wr_go, wr_col, last, ovf;
  logic [DATA_W-1:0] rx_word;

  assign is_m     = en_q && (mode_role(mode_q) == ROLE_MASTER);
  assign is_s     = en_q && (mode_role(mode_q) == ROLE_SLAVE);
  assign ss_block = is_s && (mode_q == MODE_SLV_SS) && ss_n_s;

  spi_port_clkgen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) i_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (is_m & busy_q),
    .sel_i  (mode_q[1:0]),
    .tick_i (tmr_tick_i),
    .edge_o (m_edge)
  );

  spi_port_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sck_i   (sck_i),
    .ss_ni   (ss_ni),
    .cpol_i  (cpol_q),
    .lead_o  (s_lead),
    .trail_o (s_trail),
    .ss_n_o  (ss_n_s)
  );

  // master edges alternate via mid_q; slave trailing edge needs a prior lead
  assign lead    = is_m ? (m_edge & ~mid_q) : (is_s & ~ss_block & s_lead);
  assign trail   = is_m ? (m_edge &  mid_q) : (is_s & ~ss_block & s_trail & mid_q);
  assign active  = is_m ? busy_q : (mid_q | (bit_q != '0));
  assign wr_go   = buf_wr_i & (is_m | is_s) & ~active;
  assign wr_col  = buf_wr_i & (is_m | is_s) &  active;
  assign last    = trail && (bit_q == BW'(DATA_W - 1));
  assign ovf     = last && is_s && full_q;
  assign rx_word = {sr_q[DATA_W-1:1], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      cpol_q  <= 1'b0;
      mode_q  <= '0;
      sr_q    <= '0;
      rxbuf_q <= '0;
      bit_q   <= '0;
      busy_q  <= 1'b0;
      mid_q   <= 1'b0;
      sdo_q   <= 1'b0;
      sck_q   <= 1'b0;
      full_q  <= 1'b0;
      done_q  <= 1'b0;
      wcol_q  <= 1'b0;
      rov_q   <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        en_q   <= cfg_en_i;
        cpol_q <= cfg_cpol_i;
        mode_q <= cfg_mode_i;
      end
      done_q <= last;

      if (!(is_m || is_s) || ss_block) begin
        busy_q <= 1'b0;
        bit_q  <= '0;
        mid_q  <= 1'b0;
      end else begin
        if (wr_go) begin
          sr_q   <= buf_wdata_i;
          busy_q <= is_m;
        end
        if (lead) begin
          sdo_q <= sr_q[DATA_W-1];
          sr_q  <= {sr_q[DATA_W-2:0], 1'b0};
          mid_q <= 1'b1;
        end
        if (trail) begin
          sr_q[0] <= sdi_i;
          mid_q   <= 1'b0;
          bit_q   <= last ? '0 : bit_q + 1'b1;
          if (last) busy_q <= 1'b0;
        end
      end

      if (last && !ovf) begin
        rxbuf_q <= rx_word;
        full_q  <= 1'b1;
      end else if (buf_rd_i) begin
        full_q <= 1'b0;
      end

      if (wr_col)           wcol_q <= 1'b1;
      else if (flags_clr_i) wcol_q <= 1'b0;
      if (ovf)              rov_q  <= 1'b1;
      else if (flags_clr_i) rov_q  <= 1'b0;

      if (!is_m || !busy_q) sck_q <= cpol_q;
      else if (m_edge)      sck_q <= ~sck_q;
    end
  end

  assign buf_rdata_o = rxbuf_q;
  assign buf_full_o  = full_q;
  assign done_o      = done_q;
  assign wcol_o      = wcol_q;
  assign rov_o       = rov_q;
  assign sck_o       = sck_q;
  assign sck_oe_o    = is_m;
  assign sdo_o       = sdo_q;
  assign sdo_oe_o    = is_m | (is_s & ~ss_block);
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic done_o,
  input logic buf_full_o,
  input logic wcol_o,
  input logic rov_o,
  input logic flags_clr_i,
  input logic sck_oe_o
);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  done_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> buf_full_o);
  // R7
  wcol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcol_o && !flags_clr_i) |=> wcol_o);
  // R7
  rov_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rov_o && !flags_clr_i) |=> rov_o);
  // R6
  no_master_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_oe_o && $past(sck_oe_o)) |-> !$rose(rov_o));
endmodule

bind spi_port spi_port_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_o      (done_o),
  .buf_full_o  (buf_full_o),
  .wcol_o      (wcol_o),
  .rov_o       (rov_o),
  .flags_clr_i (flags_clr_i),
  .sck_oe_o    (sck_oe_o)
);

// File: tb/test_spi_port.sv
module test_spi_port;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       cfg_we_i = 0, cfg_en_i = 0, cfg_cpol_i = 0;
  logic [3:0] cfg_mode_i = '0;
  logic       buf_wr_i = 0, buf_rd_i = 0, flags_clr_i = 0, tmr_tick_i = 0;
  logic [7:0] buf_wdata_i = '0;
  logic       sck_i = 0, ss_ni = 1, sdi_drv = 0, loop_en = 1;
  logic [7:0] buf_rdata_o;
  logic       buf_full_o, done_o, wcol_o, rov_o, sck_o, sck_oe_o, sdo_o, sdo_oe_o, sdi_i;

  int cyc = 0, n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;
  assign sdi_i = loop_en ? sdo_o : sdi_drv;

  spi_port i_spi_port (.*);

  localparam int SH = 6; // system cycles per slave SCK half period

  function automatic int div_of(input int m);
    return (m == 0) ? 4 : (m == 1) ? 16 : 64;
  endfunction
  function automatic int exp_lat(input int m);
    return 8 * div_of(m) + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input bit en, input bit cp, input logic [3:0] m);
    @(negedge clk_i); cfg_we_i = 1; cfg_en_i = en; cfg_cpol_i = cp; cfg_mode_i = m;
    @(negedge clk_i); cfg_we_i = 0;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk_i); buf_wr_i = 1; buf_wdata_i = b;
    @(negedge clk_i); buf_wr_i = 0;
  endtask

  task automatic rd();
    @(negedge clk_i); buf_rd_i = 1;
    @(negedge clk_i); buf_rd_i = 0;
  endtask

  task automatic clr();
    @(negedge clk_i); flags_clr_i = 1;
    @(negedge clk_i); flags_clr_i = 0;
  endtask

  task automatic m_xfer(input logic [7:0] b, output logic [7:0] rx, output int lat);
    int t0;
    @(negedge clk_i); buf_wr_i = 1; buf_wdata_i = b; t0 = cyc;
    @(negedge clk_i); buf_wr_i = 0;
    lat = -1;
    for (int i = 0; i < 5000; i++) begin
      if (done_o) begin lat = cyc - t0; break; end
      @(negedge clk_i);
    end
    rx = buf_rdata_o;
    @(negedge clk_i);
    chk(!done_o, "R11 done width", done_o, 0);
  endtask

  task automatic s_xfer(input logic [7:0] tx, input int nbits, input bit cp,
                        output logic [7:0] seen);
    seen = '0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk_i); sck_i = ~cp;
      repeat (SH) @(negedge clk_i);
      seen[7-i] = sdo_o;
      sdi_drv = tx[7-i];
      sck_i = cp;
      repeat (SH) @(negedge clk_i);
    end
    repeat (SH) @(negedge clk_i);
  endtask

  initial begin
    logic [7:0] b, b2, rx, seen;
    int lat, ticks;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R8 reset state
    chk(sck_oe_o == 0 && sdo_oe_o == 0, "R8 reset oe", {sck_oe_o, sdo_oe_o}, 0);
    chk(buf_full_o == 0 && wcol_o == 0 && rov_o == 0, "R8 reset flags",
        {buf_full_o, wcol_o, rov_o}, 0);
    wr(8'hA5);
    repeat (40) @(negedge clk_i);
    chk(done_o == 0 && buf_full_o == 0, "R8 disabled write", buf_full_o, 0);

    // R1 fixed dividers, random data, loopback
    for (int m = 0; m < 3; m++) begin
      cfg(1, 0, 4'(m));
      for (int k = 0; k < 3; k++) begin
        b = 8'($urandom);
        m_xfer(b, rx, lat);
        chk(rx == b, "R1 data", rx, b);
        chk(lat == exp_lat(m), "R1 latency", lat, exp_lat(m));
        chk(buf_full_o == 1, "R11 full set", buf_full_o, 1);
        rd();
        chk(buf_full_o == 0, "R11 read clears", buf_full_o, 0);
      end
    end
    chk(sck_o == 0, "R4 idle low", sck_o, 0);

    // R4 idle high
    cfg(1, 1, 4'b0000);
    chk(sck_o == 1, "R4 idle high", sck_o, 1);
    m_xfer(8'h3C, rx, lat);
    chk(rx == 8'h3C && sck_o == 1, "R4 cpol1 xfer", rx, 8'h3C);

    // R6 two unread master bytes: no overflow, newest kept
    m_xfer(8'h96, rx, lat);
    chk(rov_o == 0, "R6 no master ovf", rov_o, 0);
    chk(buf_rdata_o == 8'h96, "R6 buffer replaced", buf_rdata_o, 8'h96);
    rd();

    // R7 write collision
    cfg(1, 0, 4'b0001);
    wr(8'hC3);
    repeat (5) @(negedge clk_i);
    wr(8'h11);
    chk(wcol_o == 1, "R7 wcol set", wcol_o, 1);
    for (int i = 0; i < 500 && !done_o; i++) @(negedge clk_i);
    chk(buf_rdata_o == 8'hC3, "R7 colliding write ignored", buf_rdata_o, 8'hC3);
    repeat (4) @(negedge clk_i);
    chk(wcol_o == 1, "R7 wcol sticky", wcol_o, 1);
    clr();
    chk(wcol_o == 0, "R7 wcol cleared", wcol_o, 0);
    rd();

    // R2 timer-driven SCK
    cfg(1, 0, 4'b0011);
    b = 8'($urandom);
    wr(b);
    ticks = 0;
    for (int i = 0; i < 40 && !done_o; i++) begin
      @(negedge clk_i); tmr_tick_i = 1;
      @(negedge clk_i); tmr_tick_i = 0; ticks++;
    end
    chk(ticks == 16, "R2 tick count", ticks, 16);
    chk(buf_rdata_o == b, "R2 data", buf_rdata_o, b);
    rd();

    // R3/R10 slave ignoring SS, cpol=1
    loop_en = 0;
    sck_i = 1; ss_ni = 1;
    cfg(1, 1, 4'b0101);
    chk(sdo_oe_o == 1 && sck_oe_o == 0, "R3 slave oe", {sdo_oe_o, sck_oe_o}, 2);
    b = 8'($urandom); b2 = 8'($urandom);
    wr(b);
    s_xfer(b2, 8, 1, seen);
    chk(seen == b, "R10 sdo msb first", seen, b);
    chk(buf_rdata_o == b2 && buf_full_o, "R3 slave rx", buf_rdata_o, b2);

    // R5 overflow on unread byte
    s_xfer(~b2, 8, 1, seen);
    chk(rov_o == 1, "R5 ovf set", rov_o, 1);
    chk(buf_rdata_o == b2, "R5 old byte kept", buf_rdata_o, b2);
    clr(); rd();

    // R3 SS gating
    sck_i = 0;
    cfg(1, 0, 4'b0100);
    chk(sdo_oe_o == 0, "R3 ss high tristate", sdo_oe_o, 0);
    s_xfer(8'h5A, 8, 0, seen);
    chk(buf_full_o == 0 && done_o == 0, "R3 ss high ignored", buf_full_o, 0);
    ss_ni = 0;
    repeat (4) @(negedge clk_i);
    s_xfer(8'hF0, 3, 0, seen);
    ss_ni = 1;
    repeat (6) @(negedge clk_i);
    ss_ni = 0;
    repeat (6) @(negedge clk_i);
    b = 8'($urandom);
    s_xfer(b, 8, 0, seen);
    chk(buf_rdata_o == b && buf_full_o, "R3 ss abort resync", buf_rdata_o, b);
    rd();
    ss_ni = 1; loop_en = 1;

    // R9 reserved code
    cfg(1, 0, 4'b1001);
    wr(8'h77);
    repeat (40) @(negedge clk_i);
    chk(sck_oe_o == 0 && wcol_o == 0 && buf_full_o == 0, "R9 reserved idle",
        {sck_oe_o, wcol_o, buf_full_o}, 0);

    // R8 disable releases pins
    cfg(0, 0, 4'b0000);
    chk(sck_oe_o == 0 && sdo_oe_o == 0, "R8 disabled oe", {sck_oe_o, sdo_oe_o}, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule